// File: doc/BRIEF.md
# Two-Path Quantizer Back End with Difference Correction

This block sits behind the two flash quantizers of a two-path, time-interleaved delta-sigma modulator whose loop integrators are shared between the paths. It accepts the thermometer words of both quantizers once per half-rate slot. It counts the ones in each word to form binary codes. The first path's quantizer is fed from the second path's feedback value of the previous slot rather than the current one, so its code carries a known error. The block removes that error by subtracting a power-of-two-scaled first difference of the second path's code. It then limits the result to the 4-bit feedback range.

The corrected first-path code and the second-path code drive the two feedback DACs. They are also interleaved onto one full-rate output word for the decimator. The first-path code is sent first in each pair, and a slot flag says which path the current word belongs to. Everything runs from one full-rate clock. An internal phase bit marks the capture and update cycles, which alternate.

Top module: `dual_path_backend`

## Requirements
- R1: Each thermometer word is converted by counting its set bits, whatever their positions. The first word (31 bits) gives 0..31 and the second word (15 bits) gives 0..15, so a bubble changes the result only through the number of set bits.
- R2: The raw corrected code is y1e - 16 - (y2 - y2p) * 2^SHIFT + 8, computed in signed arithmetic. Here y1e is the first count, y2 the second count, y2p the second count of the previous pair, and SHIFT defaults to 1 (c = 2).
- R3: y2p is the second count captured in the preceding pair; for the first pair after reset it is mid-scale 8.
- R4: The corrected code is clamped to 0..15: negative raw values give 0 and values above 15 give 15.
- R5: clip_o goes high on the same edge that loads a clamped code into dac1_o, and it then stays high until reset.
- R6: Inputs are captured on the first rising edge after reset and on every second edge after that. One edge after a capture, data_o carries the corrected code with slot_o = 0. On the next edge, which is also the next capture, data_o carries the second count of that pair with slot_o = 1.
- R7: dac1_o and dac2_o load the corrected code and the second count one edge after each capture, and they hold those values for two clocks.
- R8: valid_o stays low until the first slot_o = 0 word appears, and it stays high from then until reset.
- R9: While rst_ni is low, data_o, dac1_o, dac2_o, slot_o, valid_o and clip_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Full-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| therm1_i | input | 31 | First quantizer thermometer word |
| therm2_i | input | 15 | Second quantizer thermometer word |
| data_o | output | 4 | Interleaved full-rate code |
| slot_o | output | 1 | 0 = first-path word, 1 = second-path word |
| valid_o | output | 1 | Interleaved stream holds real data |
| dac1_o | output | 4 | Corrected code for first feedback DAC |
| dac2_o | output | 4 | Second-path code for second feedback DAC |
| clip_o | output | 1 | Sticky clamp indicator |

## Verification
Two things can happen on the same update edge. The difference correction can drive the raw code past a rail, which loads a clamped code into dac1_o. In that same edge, the sticky clip flag rises and the slot-0 word goes out on data_o. Directed pairs provoke this by making large second-path jumps in both directions; one such pair keeps the first count at full scale while the second count swings from 0 to 15. The bench judges each of these edges against a model of the clamp. It checks data_o, dac1_o and clip_o together, and it checks that the slot-1 word that follows still carries the unaltered second count.

// File: rtl/dual_path_pkg.sv
package dual_path_pkg;
  typedef enum logic {
    SLOT_PATH1 = 1'b0,
    SLOT_PATH2 = 1'b1
  } slot_e;
endpackage

// File: rtl/therm_count.sv
module therm_count #(
  parameter int N  = 15,
  localparam int OW = $clog2(N + 1)
) (
  input  logic [N-1:0]  therm_i,
  output logic [OW-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < N; i++) count_o = count_o + OW'(therm_i[i]);
  end
endmodule

// File: rtl/path_corrector.sv
module path_corrector #(
  parameter int C1_W   = 5,
  parameter int C2_W   = 4,
  parameter int CODE_W = 4,
  parameter int SHIFT  = 1,
  localparam int SW    = C1_W + SHIFT + 3,
  localparam int MID1  = 2 ** (C1_W - 1),
  localparam int MID2  = 2 ** (C2_W - 1),
  localparam int MIDO  = 2 ** (CODE_W - 1),
  localparam int MAXO  = 2 ** CODE_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              upd_i,
  input  logic [C1_W-1:0]   cnt1_i,
  input  logic [C2_W-1:0]   cnt2_i,
  output logic [CODE_W-1:0] p1_next_o,
  output logic [CODE_W-1:0] dac1_o,
  output logic [CODE_W-1:0] dac2_o,
  output logic              clip_o
);
  logic [C1_W-1:0]   c1_q;
  logic [C2_W-1:0]   c2_q, prev_q;
  logic [CODE_W-1:0] dac1_q, dac2_q;
  logic              clip_q;
  logic signed [SW-1:0] e1, d2, raw;
  logic              out_of_range;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_q   <= '0;
      c2_q   <= C2_W'(MID2);
      prev_q <= C2_W'(MID2);
    end else if (cap_i) begin
      c1_q   <= cnt1_i;
      c2_q   <= cnt2_i;
      prev_q <= c2_q;
    end
  end

  // Signed correction around mid-scale; c = 2^SHIFT is a plain shift
  always_comb begin
    e1  = $signed(SW'(c1_q));
    d2  = $signed(SW'(c2_q)) - $signed(SW'(prev_q));
    raw = e1 - $signed(SW'(MID1)) - (d2 <<< SHIFT) + $signed(SW'(MIDO));
    out_of_range = 1'b0;
    if (raw < 0) begin
      p1_next_o    = '0;
      out_of_range = 1'b1;
    end else if (raw > $signed(SW'(MAXO))) begin
      p1_next_o    = CODE_W'(MAXO);
      out_of_range = 1'b1;
    end else begin
      p1_next_o = raw[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac1_q <= '0;
      dac2_q <= '0;
      clip_q <= 1'b0;
    end else if (upd_i) begin
      dac1_q <= p1_next_o;
      dac2_q <= CODE_W'(c2_q);
      if (out_of_range) clip_q <= 1'b1;
    end
  end

  assign dac1_o = dac1_q;
  assign dac2_o = dac2_q;
  assign clip_o = clip_q;

  AST_CLIP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clip_q |=> clip_q); // R5
  AST_CLIP_ON_RAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && (raw < 0 || raw > $signed(SW'(MAXO)))) |=> clip_q); // R4
  AST_DAC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(dac1_q) && $stable(dac2_q))); // R7
endmodule

// File: rtl/path_interleaver.sv
module path_interleaver
  import dual_path_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              upd_i,
  input  logic [CODE_W-1:0] p1_i,
  input  logic [CODE_W-1:0] p2_i,
  output logic [CODE_W-1:0] data_o,
  output logic              slot_o,
  output logic              valid_o
);
  logic [CODE_W-1:0] data_q;
  slot_e             slot_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      slot_q  <= SLOT_PATH1;
      valid_q <= 1'b0;
    end else if (upd_i) begin
      data_q  <= p1_i;
      slot_q  <= SLOT_PATH1;
      valid_q <= 1'b1;
    end else if (cap_i && valid_q) begin
      data_q  <= p2_i;
      slot_q  <= SLOT_PATH2;
    end
  end

  assign data_o  = data_q;
  assign slot_o  = slot_q;
  assign valid_o = valid_q;

  AST_VALID_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q); // R8
  AST_SLOT_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && $past(valid_q)) |-> (slot_q != $past(slot_q))); // R6
  AST_FIRST_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> (slot_q == SLOT_PATH1)); // R8
endmodule

// File: rtl/dual_path_backend.sv
module dual_path_backend #(
  parameter int TH1_N  = 31,
  parameter int TH2_N  = 15,
  parameter int CODE_W = 4,
  parameter int SHIFT  = 1,
  localparam int C1_W  = $clog2(TH1_N + 1),
  localparam int C2_W  = $clog2(TH2_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TH1_N-1:0]  therm1_i,
  input  logic [TH2_N-1:0]  therm2_i,
  output logic [CODE_W-1:0] data_o,
  output logic              slot_o,
  output logic              valid_o,
  output logic [CODE_W-1:0] dac1_o,
  output logic [CODE_W-1:0] dac2_o,
  output logic              clip_o
);
  logic              ph_q;
  logic              cap, upd;
  logic [C1_W-1:0]   cnt1;
  logic [C2_W-1:0]   cnt2;
  logic [CODE_W-1:0] p1_next, dac2_w;

  // Half-rate phase: 0 = capture slot, 1 = update slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end
  assign cap = ~ph_q;
  assign upd = ph_q;

  therm_count #(.N(TH1_N)) u_cnt1 (.therm_i(therm1_i), .count_o(cnt1));
  therm_count #(.N(TH2_N)) u_cnt2 (.therm_i(therm2_i), .count_o(cnt2));

  path_corrector #(
    .C1_W(C1_W), .C2_W(C2_W), .CODE_W(CODE_W), .SHIFT(SHIFT)
  ) u_corr (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .upd_i(upd),
    .cnt1_i(cnt1), .cnt2_i(cnt2),
    .p1_next_o(p1_next), .dac1_o(dac1_o), .dac2_o(dac2_w), .clip_o(clip_o)
  );
  assign dac2_o = dac2_w;

  path_interleaver #(.CODE_W(CODE_W)) u_ilv (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .upd_i(upd),
    .p1_i(p1_next), .p2_i(dac2_w),
    .data_o(data_o), .slot_o(slot_o), .valid_o(valid_o)
  );

  AST_SLOT1_MATCHES_DAC2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && slot_o) |-> (data_o == dac2_o)); // R6
  AST_SLOT0_MATCHES_DAC1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !slot_o) |-> (data_o == dac1_o)); // R7
endmodule

// File: tb/sim_dual_path_backend.sv
module sim_dual_path_backend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] therm1 = '0;
  logic [14:0] therm2 = '0;
  logic [3:0]  data, dac1, dac2;
  logic        slot, valid, clip;

  int n_chk = 0, n_bad = 0;
  int prev_y2 = 8;
  int last_y2 = 0;
  bit have_prev = 0;
  bit exp_clip = 0;

  always #2.5 clk = ~clk;

  dual_path_backend u0 (
    .clk_i(clk), .rst_ni(rst_n), .therm1_i(therm1), .therm2_i(therm2),
    .data_o(data), .slot_o(slot), .valid_o(valid),
    .dac1_o(dac1), .dac2_o(dac2), .clip_o(clip)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", req, got, exp, $time);
    end
  endtask

  function automatic int raw_code(int c1, int c2, int p);
    return c1 - 16 - (c2 - p) * 2 + 8;
  endfunction

  function automatic logic [30:0] mk1(int k, bit bubble);
    logic [30:0] v = '0;
    for (int i = 0; i < k; i++) v[i] = 1'b1;
    if (bubble && k > 1 && k < 31) begin v[k-2] = 1'b0; v[k] = 1'b1; end
    return v;
  endfunction

  function automatic logic [14:0] mk2(int k, bit bubble);
    logic [14:0] v = '0;
    for (int i = 0; i < k; i++) v[i] = 1'b1;
    if (bubble && k > 1 && k < 15) begin v[k-2] = 1'b0; v[k] = 1'b1; end
    return v;
  endfunction

  task automatic pair(logic [30:0] t1, logic [14:0] t2);
    int c1, c2, r, y1;
    therm1 = t1; therm2 = t2;
    c1 = $countones(t1); c2 = $countones(t2);
    @(posedge clk); #1;
    if (have_prev) begin
      chk("R6 slot1 data", int'(data), last_y2);
      chk("R6 slot1 flag", int'(slot), 1);
    end else begin
      chk("R8 valid low before first pair", int'(valid), 0);
    end
    r = raw_code(c1, c2, prev_y2);
    y1 = (r < 0) ? 0 : (r > 15) ? 15 : r;
    if (r < 0 || r > 15) exp_clip = 1;
    @(posedge clk); #1;
    chk("R2 R4 slot0 data", int'(data), y1);
    chk("R6 slot0 flag", int'(slot), 0);
    chk("R8 valid high", int'(valid), 1);
    chk("R7 dac1", int'(dac1), y1);
    chk("R1 R7 dac2", int'(dac2), c2);
    chk("R5 clip", int'(clip), int'(exp_clip));
    prev_y2 = c2; last_y2 = c2; have_prev = 1;
  endtask

  initial begin
    void'($urandom(32'd20250611));
    #12;
    chk("R9 reset data", int'(data), 0);
    chk("R9 reset valid", int'(valid), 0);
    chk("R9 reset slot", int'(slot), 0);
    chk("R9 reset clip", int'(clip), 0);
    chk("R9 reset dac1", int'(dac1), 0);
    chk("R9 reset dac2", int'(dac2), 0);
    @(negedge clk); rst_n = 1'b1;
    // R3: first pair uses mid-scale previous sample -> 8
    pair(mk1(16, 0), mk2(8, 0));
    // R3: previous sample now 8, step to 9 -> 15-16-2+8=5
    pair(mk1(15, 0), mk2(9, 0));
    // R1: bubbles keep counts
    pair(mk1(17, 1), mk2(9, 1));
    pair(mk1(16, 1), mk2(8, 1));
    // R4 low rail with R5 flag: 31 full scale, y2 0 -> 15
    pair(mk1(31, 0), mk2(0, 0));
    pair(mk1(31, 0), mk2(15, 0));
    // R4 high rail: y2 15 -> 0 with small y1e
    pair(mk1(0, 0), mk2(0, 0));
    for (int i = 0; i < 400; i++)
      pair(mk1(int'($urandom_range(31, 0)), bit'($urandom_range(1, 0))),
           mk2(int'($urandom_range(15, 0)), bit'($urandom_range(1, 0))));
    @(posedge clk); #1;
    chk("R6 final slot1 data", int'(data), last_y2);
    chk("R6 final slot1 flag", int'(slot), 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule